// File: doc/BRIEF.md
# Microcoded Next-State Address Sequencer

This block is the sequencing half of a microprogrammed controller. Every clock cycle it forms the 6-bit control-store address of the next microstate and registers it as the current state. The current microstate supplies a sequencing word with three fields: a 6-bit jump target, a 3-bit condition selector and a decode flag. When the decode flag is set, the next address is the instruction opcode with two zeros above it. Otherwise the next address is the jump target, with at most one qualifier bit OR-ed into one fixed bit position. The condition selector picks which qualifier it is: memory ready, branch enable, addressing mode, user privilege or interrupt request.

A small built-in control store holds only the sequencing words for a subset of states: the fetch loop and a few branch points. The block also holds the branch-enable register, which is loaded from the condition codes and the branch-mask field of the instruction. It also holds the register-specifier multiplexers for the destination and the first source register.

Reset is synchronous and active high, and it loads the fetch state. The instruction arrives as its upper ten bits, `instr_hi[9:0]`:
- `instr_hi[9:6]` is the opcode.
- `instr_hi[5:3]` is the upper register field. Its top bit `instr_hi[5]` is also the addressing-mode bit.
- `instr_hi[2:0]` is the lower register field.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes 18 (binary 010010) after that edge and `ben` becomes 0.
- R2: On every rising edge without reset, `state_addr` takes the value `next_addr` held just before the edge.
- R3: In state 32 the decode flag is set, and `next_addr` equals {2'b00, `instr_hi[9:6]`}. Opcode 1101 therefore leads to state 13, and opcode 0000 leads to state 0.
- R4: State 33 uses condition code 001, which ORs `mem_ready` into bit 1 of jump target 33. The next state is 33 while `mem_ready` is 0 and 35 when it is 1. State 35 goes unconditionally to 32.
- R5: State 18 uses condition code 101, which ORs `int_req` into bit 4 of jump target 33. The next state is 33 when `int_req` is 0 and 49 when it is 1. In no other state does `int_req` change `next_addr`.
- R6: State 49 uses condition code 100, which ORs `psr_user` into bit 3 of jump target 37. The next state is 37 in supervisor mode (0) and 45 in user mode (1).
- R7: State 0 uses condition code 010, which ORs the registered `ben` into bit 2 of jump target 18. The next state is 22 when `ben` is 1 and 18 when it is 0.
- R8: State 4 uses condition code 011, which ORs `instr_hi[5]` into bit 0 of jump target 20. The next state is 21 or 20.
- R9: `ben` loads (`instr_hi[5]`&`cc_n`) | (`instr_hi[4]`&`cc_z`) | (`instr_hi[3]`&`cc_p`) at the edge that leaves state 32, and holds its value at every other edge.
- R10: `dr` is `instr_hi[5:3]` when `dr_sel` is 00 or 11, 111 when `dr_sel` is 01, and 110 when `dr_sel` is 10.
- R11: `sr1` is `instr_hi[5:3]` when `sr1_sel` is 00, `instr_hi[2:0]` when it is 01, and 110 when it is 10 or 11.
- R12: Every state not named in R3 to R8 holds an unconditional jump to 18. This includes 13, 20, 21, 22, 37 and 45.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to state 18 |
| instr_hi | input | 10 | Instruction bits: [9:6] opcode, [5:3] upper field, [2:0] lower field |
| cc_n | input | 1 | Negative condition code |
| cc_z | input | 1 | Zero condition code |
| cc_p | input | 1 | Positive condition code |
| psr_user | input | 1 | Privilege bit, 1 = user mode |
| int_req | input | 1 | Interrupt request qualifier |
| mem_ready | input | 1 | Memory operation completes this cycle |
| dr_sel | input | 2 | Destination register specifier select |
| sr1_sel | input | 2 | First source register specifier select |
| state_addr | output | 6 | Registered current microstate address |
| next_addr | output | 6 | Combinational next microstate address |
| ben | output | 1 | Registered branch-enable bit |
| dr | output | 3 | Destination register specifier |
| sr1 | output | 3 | First source register specifier |

## Verification
A directed fetch loop first holds `mem_ready` low for several cycles in the wait state. This shows that bit 1 is set only when the ready qualifier is live, and that the sequencer stays in place otherwise. Random instructions, condition codes, privilege, interrupt and ready values then drive the sequencer through decode into the branch, subroutine, interrupt and illegal-opcode entry states. Because `int_req` is high on many cycles outside the fetch state, this stimulus separates a qualifier that is gated by its own condition code from one that leaks into other states. Independent random selects on the register multiplexers check every encoding, including the unused codes.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int ADDR_W  = 6;
    localparam int OPC_W   = 4;
    localparam int RSEL_W  = 3;
    localparam int INSTR_W = OPC_W + 2 * RSEL_W;
    localparam int NQ      = 5;

    typedef logic [ADDR_W-1:0] uaddr_t;

    typedef enum logic [2:0] {
        COND_ALWAYS = 3'd0,
        COND_READY  = 3'd1,
        COND_BRANCH = 3'd2,
        COND_AMODE  = 3'd3,
        COND_PRIV   = 3'd4,
        COND_INTR   = 3'd5
    } cond_e;

    typedef struct packed {
        logic   ird;
        cond_e  cond;
        uaddr_t jump;
        logic   ld_ben;
    } seq_word_t;

    // qualifier order: ready, branch, amode, priv, intr
    localparam logic [2:0] Q_CODE [NQ] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
    localparam int         Q_BIT  [NQ] = '{1, 2, 0, 3, 4};

    localparam uaddr_t ST_BR      = uaddr_t'(0);
    localparam uaddr_t ST_JSR     = uaddr_t'(4);
    localparam uaddr_t ST_FETCH   = uaddr_t'(18);
    localparam uaddr_t ST_JSR_TGT = uaddr_t'(20);
    localparam uaddr_t ST_DECODE  = uaddr_t'(32);
    localparam uaddr_t ST_WAIT    = uaddr_t'(33);
    localparam uaddr_t ST_LOADIR  = uaddr_t'(35);
    localparam uaddr_t ST_INT_SUP = uaddr_t'(37);
    localparam uaddr_t ST_INT     = uaddr_t'(49);

    localparam logic [RSEL_W-1:0] REG_LINK  = 3'b111;
    localparam logic [RSEL_W-1:0] REG_STACK = 3'b110;

    typedef enum logic [1:0] {
        DRS_FIELD = 2'd0,
        DRS_LINK  = 2'd1,
        DRS_STACK = 2'd2,
        DRS_SPARE = 2'd3
    } dr_sel_e;

    typedef enum logic [1:0] {
        S1S_UPPER = 2'd0,
        S1S_LOWER = 2'd1,
        S1S_STACK = 2'd2,
        S1S_SPARE = 2'd3
    } sr1_sel_e;

    function automatic seq_word_t mk_word(logic ird, cond_e cond,
                                          uaddr_t jump, logic ld_ben);
        seq_word_t w;
        w.ird    = ird;
        w.cond   = cond;
        w.jump   = jump;
        w.ld_ben = ld_ben;
        return w;
    endfunction

endpackage

// File: rtl/useq_ctrl_store.sv
module useq_ctrl_store
    import useq_pkg::*;
(
    input  uaddr_t    addr,
    output seq_word_t word
);

    always_comb begin
        case (addr)
            ST_FETCH:  word = mk_word(1'b0, COND_INTR,   ST_WAIT,    1'b0);
            ST_WAIT:   word = mk_word(1'b0, COND_READY,  ST_WAIT,    1'b0);
            ST_LOADIR: word = mk_word(1'b0, COND_ALWAYS, ST_DECODE,  1'b0);
            ST_DECODE: word = mk_word(1'b1, COND_ALWAYS, ST_FETCH,   1'b1);
            ST_BR:     word = mk_word(1'b0, COND_BRANCH, ST_FETCH,   1'b0);
            ST_JSR:    word = mk_word(1'b0, COND_AMODE,  ST_JSR_TGT, 1'b0);
            ST_INT:    word = mk_word(1'b0, COND_PRIV,   ST_INT_SUP, 1'b0);
            default:   word = mk_word(1'b0, COND_ALWAYS, ST_FETCH,   1'b0);
        endcase
    end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
    import useq_pkg::*;
(
    input  seq_word_t        word,
    input  logic [OPC_W-1:0] opcode,
    input  logic             q_ready,
    input  logic             q_branch,
    input  logic             q_amode,
    input  logic             q_priv,
    input  logic             q_intr,
    output uaddr_t           next_addr
);

    logic [NQ-1:0] qual;
    logic [NQ-1:0] hit;
    uaddr_t        mask;

    assign qual = {q_intr, q_priv, q_amode, q_branch, q_ready};

    for (genvar g = 0; g < NQ; g++) begin : g_qual
        assign hit[g] = (3'(word.cond) == Q_CODE[g]) & qual[g];
    end

    always_comb begin
        mask = '0;
        for (int i = 0; i < NQ; i++) begin
            mask = mask | (uaddr_t'(hit[i]) << Q_BIT[i]);
        end
    end

    always_comb begin
        if (word.ird) begin
            next_addr = {{(ADDR_W-OPC_W){1'b0}}, opcode};
        end else begin
            next_addr = word.jump | mask;
        end
    end

endmodule

// File: rtl/useq_branch_en.sv
module useq_branch_en
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [RSEL_W-1:0] nzp_mask,
    input  logic              cc_n,
    input  logic              cc_z,
    input  logic              cc_p,
    output logic              ben
);

    logic taken;

    assign taken = (nzp_mask[2] & cc_n) | (nzp_mask[1] & cc_z) | (nzp_mask[0] & cc_p);

    always_ff @(posedge clk) begin
        if (rst) begin
            ben <= 1'b0;
        end else if (load) begin
            ben <= taken;
        end
    end

endmodule

// File: rtl/useq_reg_sel.sv
module useq_reg_sel
    import useq_pkg::*;
(
    input  logic [RSEL_W-1:0] field_hi,
    input  logic [RSEL_W-1:0] field_lo,
    input  logic [1:0]        dr_sel,
    input  logic [1:0]        sr1_sel,
    output logic [RSEL_W-1:0] dr,
    output logic [RSEL_W-1:0] sr1
);

    always_comb begin
        case (dr_sel_e'(dr_sel))
            DRS_LINK:  dr = REG_LINK;
            DRS_STACK: dr = REG_STACK;
            default:   dr = field_hi;
        endcase
    end

    always_comb begin
        case (sr1_sel_e'(sr1_sel))
            S1S_UPPER: sr1 = field_hi;
            S1S_LOWER: sr1 = field_lo;
            default:   sr1 = REG_STACK;
        endcase
    end

endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [INSTR_W-1:0]    instr_hi,
    input  logic                  cc_n,
    input  logic                  cc_z,
    input  logic                  cc_p,
    input  logic                  psr_user,
    input  logic                  int_req,
    input  logic                  mem_ready,
    input  logic [1:0]            dr_sel,
    input  logic [1:0]            sr1_sel,
    output logic [ADDR_W-1:0]     state_addr,
    output logic [ADDR_W-1:0]     next_addr,
    output logic                  ben,
    output logic [RSEL_W-1:0]     dr,
    output logic [RSEL_W-1:0]     sr1
);

    localparam int HI_LSB = RSEL_W;
    localparam int OP_LSB = 2 * RSEL_W;

    seq_word_t         word;
    uaddr_t            state_q;
    uaddr_t            nxt;
    logic [OPC_W-1:0]  opcode;
    logic [RSEL_W-1:0] field_hi;
    logic [RSEL_W-1:0] field_lo;

    assign opcode   = instr_hi[OP_LSB +: OPC_W];
    assign field_hi = instr_hi[HI_LSB +: RSEL_W];
    assign field_lo = instr_hi[0 +: RSEL_W];

    useq_ctrl_store u_store (
        .addr (state_q),
        .word (word)
    );

    useq_branch_en u_ben (
        .clk      (clk),
        .rst      (rst),
        .load     (word.ld_ben),
        .nzp_mask (field_hi),
        .cc_n     (cc_n),
        .cc_z     (cc_z),
        .cc_p     (cc_p),
        .ben      (ben)
    );

    useq_next_addr u_next (
        .word      (word),
        .opcode    (opcode),
        .q_ready   (mem_ready),
        .q_branch  (ben),
        .q_amode   (field_hi[RSEL_W-1]),
        .q_priv    (psr_user),
        .q_intr    (int_req),
        .next_addr (nxt)
    );

    useq_reg_sel u_regsel (
        .field_hi (field_hi),
        .field_lo (field_lo),
        .dr_sel   (dr_sel),
        .sr1_sel  (sr1_sel),
        .dr       (dr),
        .sr1      (sr1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= nxt;
        end
    end

    assign state_addr = state_q;
    assign next_addr  = nxt;

endmodule

// File: rtl/useq_chk.sv
module useq_chk (
    input logic       clk,
    input logic       rst,
    input logic [5:0] state_addr,
    input logic [5:0] next_addr,
    input logic       ben,
    input logic [2:0] dr,
    input logic [1:0] dr_sel
);

    AST_RESET_FETCH: assert property (@(posedge clk)
        rst |=> (state_addr == 6'd18 && !ben)) else $error("reset state"); // R1

    AST_STATE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (state_addr == $past(next_addr))) else $error("state load"); // R2

    AST_DECODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state_addr == 6'd32) |-> (next_addr[5:4] == 2'b00)) else $error("decode"); // R3

    AST_WAIT_EXITS: assert property (@(posedge clk) disable iff (rst)
        (state_addr == 6'd33) |-> (next_addr == 6'd33 || next_addr == 6'd35)) else $error("wait"); // R4

    AST_FETCH_EXITS: assert property (@(posedge clk) disable iff (rst)
        (state_addr == 6'd18) |-> (next_addr == 6'd33 || next_addr == 6'd49)) else $error("fetch"); // R5

    AST_PRIV_EXITS: assert property (@(posedge clk) disable iff (rst)
        (state_addr == 6'd49) |-> (next_addr == 6'd37 || next_addr == 6'd45)) else $error("priv"); // R6

    AST_BEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_addr != 6'd32) |=> $stable(ben)) else $error("ben hold"); // R9

    AST_DR_LINK: assert property (@(posedge clk) disable iff (rst)
        (dr_sel == 2'b01) |-> (dr == 3'b111)) else $error("dr link"); // R10

endmodule

bind useq_top useq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .state_addr (state_addr),
    .next_addr  (next_addr),
    .ben        (ben),
    .dr         (dr),
    .dr_sel     (dr_sel)
);

// File: tb/useq_top_tb.sv
`timescale 1ns/1ps
module useq_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] instr_hi = '0;
    logic       cc_n = 0, cc_z = 0, cc_p = 0;
    logic       psr_user = 0, int_req = 0, mem_ready = 0;
    logic [1:0] dr_sel = '0, sr1_sel = '0;
    logic [5:0] state_addr, next_addr;
    logic       ben;
    logic [2:0] dr, sr1;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    int m_state;
    bit m_ben;

    always #10 clk = ~clk;

    useq_top u_dut (
        .clk(clk), .rst(rst), .instr_hi(instr_hi),
        .cc_n(cc_n), .cc_z(cc_z), .cc_p(cc_p),
        .psr_user(psr_user), .int_req(int_req), .mem_ready(mem_ready),
        .dr_sel(dr_sel), .sr1_sel(sr1_sel),
        .state_addr(state_addr), .next_addr(next_addr),
        .ben(ben), .dr(dr), .sr1(sr1)
    );

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (state %0d)", tag, actual, expected, m_state);
        end
    endtask

    function automatic int ref_next();
        case (m_state)
            18: return int_req ? 49 : 33;
            33: return mem_ready ? 35 : 33;
            35: return 32;
            32: return int'(instr_hi[9:6]);
            0:  return m_ben ? 22 : 18;
            4:  return instr_hi[5] ? 21 : 20;
            49: return psr_user ? 45 : 37;
            default: return 18;
        endcase
    endfunction

    function automatic string tag_of(int s);
        case (s)
            18: return "R5";
            33, 35: return "R4";
            32: return "R3";
            0:  return "R7";
            4:  return "R8";
            49: return "R6";
            default: return "R12";
        endcase
    endfunction

    function automatic int ref_dr();
        case (dr_sel)
            2'd1: return 7;
            2'd2: return 6;
            default: return int'(instr_hi[5:3]);
        endcase
    endfunction

    function automatic int ref_sr1();
        case (sr1_sel)
            2'd0: return int'(instr_hi[5:3]);
            2'd1: return int'(instr_hi[2:0]);
            default: return 6;
        endcase
    endfunction

    // called just after a falling edge with inputs already applied
    task automatic step();
        int exp_n;
        #2;
        exp_n = ref_next();
        check("R2 state", int'(state_addr), m_state);
        check(tag_of(m_state), int'(next_addr), exp_n);
        check("R9 ben", int'(ben), int'(m_ben));
        check("R10 dr", int'(dr), ref_dr());
        check("R11 sr1", int'(sr1), ref_sr1());
        @(posedge clk);
        if (m_state == 32)
            m_ben = (instr_hi[5] & cc_n) | (instr_hi[4] & cc_z) | (instr_hi[3] & cc_p);
        m_state = exp_n;
        @(negedge clk);
    endtask

    task automatic randomize_inputs(int int_pct, int rdy_pct);
        instr_hi  = 10'($urandom);
        {cc_n, cc_z, cc_p} = 3'($urandom);
        psr_user  = 1'($urandom);
        int_req   = (($urandom % 100) < int_pct);
        mem_ready = (($urandom % 100) < rdy_pct);
        dr_sel    = 2'($urandom);
        sr1_sel   = 2'($urandom);
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            bad++;
            checks++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 state", int'(state_addr), 18);
        check("R1 ben", int'(ben), 0);
        rst = 1'b0;
        m_state = 18;
        m_ben = 0;

        // directed fetch loop: R low three cycles, interrupt raised inside wait
        int_req = 0; mem_ready = 0; instr_hi = 10'b1101_000_000;
        step();                         // 18 -> 33
        int_req = 1;
        repeat (3) step();              // 33 stays, R5: int ignored
        int_req = 0; mem_ready = 1;
        step();                         // 33 -> 35
        step();                         // 35 -> 32
        step();                         // 32 -> 13 (R3 illegal opcode)
        step();                         // 13 -> 18 (R12)
        // branch taken: opcode 0000, mask n, cc_n set
        step();                         // 18 -> 33
        step();                         // 33 -> 35
        step();                         // 35 -> 32
        instr_hi = 10'b0000_100_000; {cc_n, cc_z, cc_p} = 3'b100;
        step();                         // 32 -> 0, ben loads 1
        {cc_n, cc_z, cc_p} = 3'b000;
        step();                         // 0 -> 22 (R7)
        check("R7 branch taken", m_state, 22);
        step();                         // 22 -> 18
        int_req = 1;
        step();                         // 18 -> 49 (R5)
        psr_user = 1;
        step();                         // 49 -> 45 (R6)
        int_req = 0; psr_user = 0;

        for (int i = 0; i < 4000; i++) begin
            randomize_inputs(30, 50);
            step();
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule